// File: doc/BRIEF.md
# Quadrature Demodulating Boxcar Decimator

This block turns a stream of real ADC samples into averaged baseband in-phase (I) and quadrature (Q) words. The RF signal is assumed to be sampled at exactly four times its intermediate frequency. Successive samples therefore line up with the cosine and sine axes in turn, with the sign flipping every second sample. The demodulation needs only sample ordering and sign alternation. It uses no multiplier and no numerically controlled oscillator.

Each sample goes into one of two accumulators according to a four-step phase counter. After a window of a power-of-two number of quadruples, each sum is divided by an arithmetic right shift. The results are copied to the output registers and a one-cycle valid pulse is raised. The window length is chosen by a 4-bit setting. The setting is captured only when the sequence restarts, which happens on a sync pulse or on the first clock after reset. This allows a downstream capture stage to align its output stream with other channels that share the same sync.

Top module: `iq_boxcar_decim`

## Requirements
- R1: While reset is low, and immediately after it, `i_out_o`, `q_out_o`, `ovr_o` and `valid_o` are all zero.
- R2: The ADC word carries a 14-bit two's-complement sample in bits 13:0 and an overrange flag in bit 14. Counting from the start of a window, a sample at position 4n adds to I, one at 4n+1 adds to Q, one at 4n+2 subtracts from I, and one at 4n+3 subtracts from Q.
- R3: With an effective setting D, a window holds 2^(D+2) samples. Each output equals its window sum shifted arithmetically right by D+1, which rounds toward negative infinity. Settings of 15 act as 14.
- R4: Results and `valid_o` are registered on the clock edge that takes the last sample of a window. `valid_o` is high for exactly that one cycle, and every output holds its value between pulses.
- R5: A cycle with `sync_i` high clears both accumulators and the sticky overrange state, and restarts the phase sequence. The sample presented in that cycle is discarded, and a partly collected window produces no output.
- R6: The decimation setting is captured only in a restart cycle. A change on `dec_sel_i` at any other time has no effect on the window length or the scaling.
- R7: `ovr_o` is high with a result when any sample of that window had bit 14 set. The flag is cleared for the following window.
- R8: The first clock cycle after reset release acts as a restart cycle: its sample is discarded and `dec_sel_i` is captured.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | ADC sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to `clk_i` |
| sync_i | input | 1 | Restart pulse: clears the sums, restarts the phase sequence, captures the setting |
| dec_sel_i | input | 4 | Decimation setting D; the window is 2^(D+2) samples |
| adc_word_i | input | 15 | Bit 14 is the overrange flag; bits 13:0 are the signed sample |
| i_out_o | output | 16 | Averaged in-phase result, two's complement |
| q_out_o | output | 16 | Averaged quadrature result, two's complement |
| ovr_o | output | 1 | Overrange seen anywhere in the reported window |
| valid_o | output | 1 | One-cycle marker for a new result |

## Verification
The assertions assume that `rst_ni` is released in step with the clock. They also assume that, once a restart cycle has passed, `sync_i` is held low for at least one full window whenever a result is expected.

The bench changes all inputs only on the falling clock edge. It keeps `dec_sel_i` stable across each restart cycle. It raises `sync_i` inside a window only in the one deliberate case that tests discarding a partial window. Because of this, the single-pulse and hold properties are exercised under the spacing they rely on. The result-range property is exercised both with full-scale alternating samples and with random data.

// File: rtl/iq_decim_pkg.sv
package iq_decim_pkg;

  // Position inside a group of four samples taken at four times the IF.
  typedef enum logic [1:0] {
    PH_I_ADD = 2'd0,
    PH_Q_ADD = 2'd1,
    PH_I_SUB = 2'd2,
    PH_Q_SUB = 2'd3
  } phase_e;

  // Reduce a requested setting to the largest one the accumulator can hold.
  function automatic logic [3:0] clamp_sel(input logic [3:0] sel, input int unsigned max_sel);
    if (int'(sel) > int'(max_sel)) begin
      return 4'(max_sel);
    end
    return sel;
  endfunction

endpackage

// File: rtl/iq_phase_seq.sv
module iq_phase_seq
  import iq_decim_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned MAX_DF = 14,
  parameter int unsigned CNT_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] dec_sel_i,
  output logic             restart_o,
  output logic             last_o,
  output logic [1:0]       phase_o,
  output logic [SEL_W-1:0] df_o
);

  logic             first_q, first_d;
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] quad_q, quad_d;
  logic [SEL_W-1:0] df_q, df_d;
  logic [CNT_W-1:0] quad_lim;
  logic             restart;
  logic             quad_end;

  assign restart  = sync_i | first_q;
  assign quad_lim = CNT_W'((64'd1 << df_q) - 64'd1);
  assign quad_end = (phase_q == PH_Q_SUB);
  assign last_o   = !restart && quad_end && (quad_q == quad_lim);

  assign restart_o = restart;
  assign phase_o   = phase_q;
  assign df_o      = df_q;

  always_comb begin
    first_d = 1'b0;
    phase_d = phase_q;
    quad_d  = quad_q;
    df_d    = df_q;
    if (restart) begin
      phase_d = PH_I_ADD;
      quad_d  = '0;
      df_d    = SEL_W'(clamp_sel(4'(dec_sel_i), MAX_DF));
    end else begin
      phase_d = phase_e'(phase_q + 2'd1);
      if (quad_end) begin
        quad_d = last_o ? '0 : quad_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      phase_q <= PH_I_ADD;
      quad_q  <= '0;
      df_q    <= '0;
    end else begin
      first_q <= first_d;
      phase_q <= phase_d;
      quad_q  <= quad_d;
      df_q    <= df_d;
    end
  end

endmodule

// File: rtl/iq_accum.sv
module iq_accum #(
  parameter int unsigned SMP_W = 14,
  parameter int unsigned ACC_W = 29,
  parameter int unsigned CH    = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    last_i,
  input  logic [1:0]              phase_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic signed [ACC_W-1:0] sum_o
);

  localparam int unsigned EXT_W = ACC_W - SMP_W;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] smp_ext;
  logic signed [ACC_W-1:0] term;
  logic                    mine;
  logic                    negate;

  assign smp_ext = {{EXT_W{smp_i[SMP_W-1]}}, smp_i};
  assign mine    = (phase_i[0] == CH[0]);
  assign negate  = phase_i[1];

  always_comb begin
    term = '0;
    if (mine) begin
      term = negate ? -smp_ext : smp_ext;
    end
  end

  assign sum_o = acc_q + term;

  always_comb begin
    acc_d = sum_o;
    if (clr_i || last_i) begin
      acc_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/iq_out_stage.sv
module iq_out_stage #(
  parameter int unsigned ACC_W = 29,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [SEL_W-1:0]        df_i,
  input  logic signed [ACC_W-1:0] sum_i_i,
  input  logic signed [ACC_W-1:0] sum_q_i,
  input  logic                    ovr_i,
  output logic signed [OUT_W-1:0] i_o,
  output logic signed [OUT_W-1:0] q_o,
  output logic                    ovr_o,
  output logic                    valid_o
);

  logic signed [OUT_W-1:0] i_q, i_d, q_q, q_d;
  logic                    ovr_q, ovr_d;
  logic                    vld_q, vld_d;
  logic [SEL_W:0]          shamt;
  logic signed [ACC_W-1:0] i_sh, q_sh;

  assign shamt = {1'b0, df_i} + 1'b1;
  assign i_sh  = sum_i_i >>> shamt;
  assign q_sh  = sum_q_i >>> shamt;

  always_comb begin
    i_d   = i_q;
    q_d   = q_q;
    ovr_d = ovr_q;
    vld_d = load_i;
    if (load_i) begin
      i_d   = OUT_W'(i_sh);
      q_d   = OUT_W'(q_sh);
      ovr_d = ovr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q   <= '0;
      q_q   <= '0;
      ovr_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      i_q   <= i_d;
      q_q   <= q_d;
      ovr_q <= ovr_d;
      vld_q <= vld_d;
    end
  end

  assign i_o     = i_q;
  assign q_o     = q_q;
  assign ovr_o   = ovr_q;
  assign valid_o = vld_q;

endmodule

// File: rtl/iq_boxcar_decim.sv
module iq_boxcar_decim #(
  parameter int unsigned SMP_W = 14,
  parameter int unsigned ACC_W = 29,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] dec_sel_i,
  input  logic [SMP_W:0]   adc_word_i,
  output logic [OUT_W-1:0] i_out_o,
  output logic [OUT_W-1:0] q_out_o,
  output logic             ovr_o,
  output logic             valid_o
);

  // Largest setting whose full-scale sum still fits the accumulator.
  localparam int unsigned MAX_DF = ACC_W - 1 - SMP_W;
  localparam int unsigned CNT_W  = (MAX_DF > 0) ? MAX_DF : 1;
  localparam int unsigned NCH    = 2;

  logic                    restart;
  logic                    last;
  logic [1:0]              phase;
  logic [SEL_W-1:0]        df;
  logic signed [SMP_W-1:0] smp;
  logic                    smp_ovr;
  logic signed [ACC_W-1:0] sums [NCH];
  logic                    ovr_acc_q, ovr_acc_d;
  logic                    ovr_win;
  logic signed [OUT_W-1:0] i_res, q_res;

  assign smp     = adc_word_i[SMP_W-1:0];
  assign smp_ovr = adc_word_i[SMP_W];

  iq_phase_seq #(
    .SEL_W  (SEL_W),
    .MAX_DF (MAX_DF),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .dec_sel_i (dec_sel_i),
    .restart_o (restart),
    .last_o    (last),
    .phase_o   (phase),
    .df_o      (df)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    iq_accum #(
      .SMP_W (SMP_W),
      .ACC_W (ACC_W),
      .CH    (ch)
    ) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (restart),
      .last_i  (last),
      .phase_i (phase),
      .smp_i   (smp),
      .sum_o   (sums[ch])
    );
  end

  // Sticky overrange over the current window.
  assign ovr_win = ovr_acc_q | smp_ovr;

  always_comb begin
    ovr_acc_d = ovr_win;
    if (restart || last) begin
      ovr_acc_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_acc_q <= 1'b0;
    end else begin
      ovr_acc_q <= ovr_acc_d;
    end
  end

  iq_out_stage #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .SEL_W (SEL_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last),
    .df_i    (df),
    .sum_i_i (sums[0]),
    .sum_q_i (sums[1]),
    .ovr_i   (ovr_win),
    .i_o     (i_res),
    .q_o     (q_res),
    .ovr_o   (ovr_o),
    .valid_o (valid_o)
  );

  assign i_out_o = i_res;
  assign q_out_o = q_res;

endmodule

// File: rtl/iq_boxcar_decim_chk.sv
module iq_boxcar_decim_chk #(
  parameter int unsigned SMP_W = 14,
  parameter int unsigned OUT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sync_i,
  input logic signed [OUT_W-1:0] i_out_o,
  input logic signed [OUT_W-1:0] q_out_o,
  input logic                    ovr_o,
  input logic                    valid_o
);

  localparam int HI = (2 ** (SMP_W - 1)) - 1;
  localparam int LO = -(2 ** (SMP_W - 1));

  // R4: the marker never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4: results hold while no marker is shown
  a_r4_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_out_o) && $stable(q_out_o) && $stable(ovr_o)));

  // R5: a restart never completes a window
  a_r5_sync_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !valid_o);

  // R3: an average of 14-bit differences halved stays within sample range
  a_r3_mean_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(i_out_o) >= LO && int'(i_out_o) <= HI &&
                 int'(q_out_o) >= LO && int'(q_out_o) <= HI));

endmodule

bind iq_boxcar_decim iq_boxcar_decim_chk #(
  .SMP_W (SMP_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_i  (sync_i),
  .i_out_o (i_out_o),
  .q_out_o (q_out_o),
  .ovr_o   (ovr_o),
  .valid_o (valid_o)
);

// File: tb/test_iq_boxcar_decim.sv
module test_iq_boxcar_decim;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk;
  logic        rst_n;
  logic        sync;
  logic [3:0]  dec_sel;
  logic [14:0] adc_word;
  logic [15:0] i_out;
  logic [15:0] q_out;
  logic        ovr;
  logic        valid;

  typedef struct {
    int    i;
    int    q;
    bit    ov;
    longint cyc;
    string req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  longint      cyc    = 0;
  int          act_df = 0;
  int unsigned lcg    = 32'h1234_5678;
  bit          done   = 0;

  iq_boxcar_decim i_iq_boxcar_decim (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_i     (sync),
    .dec_sel_i  (dec_sel),
    .adc_word_i (adc_word),
    .i_out_o    (i_out),
    .q_out_o    (q_out),
    .ovr_o      (ovr),
    .valid_o    (valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: pop one expected item per marker.
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (sb.size() == 0) begin
        check("R4", "unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "I", longint'($signed(i_out)), e.i);
        check(e.req, "Q", longint'($signed(q_out)), e.q);
        check("R7", "ovr", ovr, e.ov);
        check("R4", "cycle", cyc, e.cyc);
      end
    end
  end

  function automatic int pattern(int kind, int k, int a, int b);
    case (kind)
      0: return a;
      1: case (k % 4) 0: return a; 1: return b; 2: return -a; default: return -b; endcase
      default: case (k % 4) 0: return 8191; 1: return -8192; 2: return -8192; default: return 8191; endcase
    endcase
  endfunction

  // kind 0 dc, 1 tone (a,b,-a,-b), 2 full-scale extremes, 3 random.
  task automatic window(int kind, int a, int b, int ovr_at, string req);
    int     n = 4 << act_df;
    longint si = 0;
    longint sq = 0;
    bit     ov = 0;
    for (int k = 0; k < n; k++) begin
      int v;
      bit o;
      if (kind == 3) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        v = {{18{lcg[29]}}, lcg[29:16]};
      end else begin
        v = pattern(kind, k, a, b);
      end
      o = (k == ovr_at);
      ov |= o;
      case (k % 4)
        0: si += v;
        1: sq += v;
        2: si -= v;
        default: sq -= v;
      endcase
      sync = 1'b0;
      adc_word = {o, 14'(v)};
      if (k == n - 1) begin
        exp_t e;
        e.i = int'(si >>> (act_df + 1));
        e.q = int'(sq >>> (act_df + 1));
        e.ov = ov;
        e.cyc = cyc + 1;
        e.req = req;
        sb.push_back(e);
      end
      @(negedge clk);
    end
  endtask

  task automatic restart(int df, int junk);
    sync = 1'b1;
    dec_sel = 4'(df);
    adc_word = {1'b1, 14'(junk)};
    @(negedge clk);
    sync = 1'b0;
    act_df = (df > 14) ? 14 : df;
  endtask

  initial begin
    rst_n = 1'b0;
    sync = 1'b0;
    dec_sel = 4'd2;
    adc_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "i_out", i_out, 0);
    check("R1", "q_out", q_out, 0);
    check("R1", "ovr", ovr, 0);
    check("R1", "valid", valid, 0);

    // R8: first cycle after release is a discarded restart with setting 2
    rst_n = 1'b1;
    adc_word = {1'b1, 14'd5000};
    @(negedge clk);
    act_df = 2;
    check("R1", "valid after release", valid, 0);
    window(1, 1000, -300, -1, "R8");
    window(3, 0, 0, -1, "R8");

    // R2/R3 with setting 0
    restart(0, 777);
    window(2, 0, 0, -1, "R3 floor");
    window(0, 4321, 0, -1, "R2 dc");
    window(1, -5, 7, -1, "R2 tone");
    window(1, 100, 200, 2, "R7 set");
    window(1, 100, 200, -1, "R7 clear");
    window(3, 0, 0, -1, "R2 random");

    // R5: partial window then sync discards it
    restart(3, 123);
    window(3, 0, 0, -1, "R3 df3");
    for (int k = 0; k < 10; k++) begin
      adc_word = {1'b1, 14'(k * 333)};
      @(negedge clk);
    end
    restart(1, -4000);
    window(3, 0, 0, -1, "R5");

    // R6: setting change without restart is ignored
    dec_sel = 4'd0;
    window(3, 0, 0, -1, "R6");
    window(1, 3000, -2999, -1, "R6");

    // R3: setting 15 behaves as 14
    restart(15, 0);
    window(3, 0, 0, 5, "R3 clamp");

    repeat (4) @(negedge clk);
    check("R4", "pending results", sb.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule